// File: doc/BRIEF.md
# Bus master security filter

This block sits on the path from a single bus master to a downstream memory port. Every read or write is accepted on an upstream valid/ready port. In the same cycle the block presents the request address to an external attribution lookup. That lookup answers combinationally with two flags: one says the address is exempt from checking, the other says the address belongs to a non-secure region. The block combines those flags with the master's configured security level (`cfg_nonsec`) and makes one of four decisions. It can forward the transfer with the secure attribute, forward it with the non-secure attribute, neutralise it, or abort it.

A neutralised transfer never reaches the downstream port. A read returns zero, a write is dropped, and the response is OK. An aborted transfer also stays off the downstream port, but it gets an error response and sets a sticky interrupt status, which drives `irq` directly. The response style for blocked transfers is chosen by `cfg_sec_resp`. Holding `irq_clear` high clears the status and also stops any new abort from setting it. Only one transfer is in flight at a time.

Top module: `bus_sec_filter`

## Requirements
- R1: When the lookup reports the address as exempt, the transfer is forwarded downstream. `dn_req_secure` is the inverse of `cfg_nonsec` as sampled at acceptance, whatever the non-secure flag says.
- R2: When the address is not exempt and the lookup reports it non-secure, the transfer is forwarded with `dn_req_secure` = 0. This holds for either value of `cfg_nonsec`.
- R3: When the address is neither exempt nor non-secure and `cfg_nonsec` is low, the transfer is forwarded with `dn_req_secure` = 1. `cfg_sec_resp` has no effect in this case.
- R4: When the address is neither exempt nor non-secure and `cfg_nonsec` is high, the transfer is blocked. `dn_req_valid` stays low, and `up_rsp_valid` rises in the cycle after acceptance.
- R5: A blocked transfer with `cfg_sec_resp` low returns `up_rsp_rdata` = 0 and `up_rsp_err` = 0. A blocked write is discarded.
- R6: A blocked transfer with `cfg_sec_resp` high returns `up_rsp_err` = 1. When `irq_clear` is low at acceptance, `irq` is high from the next cycle on and stays high until cleared. Forwarded transfers never set it.
- R7: A cycle with `irq_clear` high leaves `irq` low in the following cycle. This includes a cycle in which an abort is accepted.
- R8: After reset, `irq` is low, `up_req_ready` is high, and both `up_rsp_valid` and `dn_req_valid` are low.
- R9: A forwarded transfer carries its address, write flag and size code downstream. The downstream read data and error flag are returned upstream unchanged. Both the downstream request and the upstream response hold steady while stalled.
- R10: The size code gives the width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Write data is little-endian in the low bytes. Byte lanes above the size are driven to zero on `dn_req_wdata`.
- R11: One transfer is outstanding at most. `up_req_ready` is low from acceptance until the upstream response handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nonsec | input | 1 | Master is configured as non-secure |
| cfg_sec_resp | input | 1 | Blocked transfers get an error response and raise the interrupt |
| irq_clear | input | 1 | Clears the interrupt status while high, and keeps it from being set |
| irq | output | 1 | Sticky abort interrupt |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_addr | input | ADDR_W | Request address |
| up_req_size | input | 2 | Size code (R10) |
| up_req_wdata | input | DATA_W | Write data, low bytes |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_rdata | output | DATA_W | Read data |
| up_rsp_err | output | 1 | Error response |
| lk_addr | output | ADDR_W | Address presented to the attribution lookup |
| lk_exempt | input | 1 | Lookup: address exempt from checking |
| lk_nonsec | input | 1 | Lookup: address in a non-secure region |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_addr | output | ADDR_W | Downstream address |
| dn_req_size | output | 2 | Downstream size code |
| dn_req_wdata | output | DATA_W | Downstream write data with unused lanes zeroed |
| dn_req_secure | output | 1 | Secure attribute of the forwarded transfer |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Downstream response ready |
| dn_rsp_rdata | input | DATA_W | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error flag |

## Verification
The assertions rely on three properties of the inputs:
- The lookup flags are a pure function of `lk_addr` and are settled in the acceptance cycle.
- `cfg_nonsec` and `cfg_sec_resp` do not change in the same cycle as an acceptance.
- The downstream side answers only while `dn_rsp_ready` is high.

The bench keeps to these rules. Its lookup model decodes two address bits combinationally. It changes configuration only on the falling edge together with the request it governs. Its downstream model raises `dn_rsp_valid` only after the request handshake has completed.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  typedef enum logic [1:0] {
    ACT_ABORT    = 2'd0,
    ACT_RAZWI    = 2'd1,
    ACT_ALLOW_S  = 2'd2,
    ACT_ALLOW_NS = 2'd3
  } bsf_action_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } bsf_state_e;

  // Priority: exempt region first, then non-secure region, then master level.
  function automatic bsf_action_e bsf_decide(input logic exempt, input logic ns_region,
                                             input logic master_ns, input logic err_resp);
    if (exempt)         return master_ns ? ACT_ALLOW_NS : ACT_ALLOW_S;
    else if (ns_region) return ACT_ALLOW_NS;
    else if (!master_ns) return ACT_ALLOW_S;
    else                return err_resp ? ACT_ABORT : ACT_RAZWI;
  endfunction

  function automatic logic bsf_is_blocked(input bsf_action_e a);
    return (a == ACT_ABORT) || (a == ACT_RAZWI);
  endfunction

endpackage

// File: rtl/bsf_decide.sv
module bsf_decide
  import bsf_pkg::*;
(
  input  logic        lk_exempt,
  input  logic        lk_nonsec,
  input  logic        cfg_nonsec,
  input  logic        cfg_sec_resp,
  output bsf_action_e action
);

  always_comb begin
    action = bsf_decide(lk_exempt, lk_nonsec, cfg_nonsec, cfg_sec_resp);
  end

endmodule

// File: rtl/bsf_irq.sv
module bsf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_evt,
  input  logic irq_clear,
  output logic irq_status
);

  logic status_q;

  // Clear has priority over a simultaneous abort.
  always_ff @(posedge clk) begin
    if (!rst_n)          status_q <= 1'b0;
    else if (irq_clear)  status_q <= 1'b0;
    else if (abort_evt)  status_q <= 1'b1;
  end

  assign irq_status = status_q;

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt && !irq_clear |=> irq_status);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status && !irq_clear |=> irq_status);

  assert_irq_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |=> !irq_status);

endmodule

// File: rtl/bsf_xfer.sv
module bsf_xfer
  import bsf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bsf_action_e       action,
  output logic              accept,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_write,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic [1:0]        up_req_size,
  input  logic [DATA_W-1:0] up_req_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [1:0]        dn_req_size,
  output logic [DATA_W-1:0] dn_req_wdata,
  output logic              dn_req_secure,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err
);

  // Little-endian lane mask: the low (8 << size) bits are live.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
    logic [DATA_W-1:0] m;
    int nbits;
    nbits = 8 << sz;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < nbits);
    return m;
  endfunction

  bsf_state_e        state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sec_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              blocked;

  assign up_req_ready = (state_q == ST_IDLE);
  assign accept       = up_req_valid && up_req_ready;
  assign blocked      = bsf_is_blocked(action);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      sec_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (blocked) begin
              rdata_q <= '0;
              err_q   <= (action == ACT_ABORT);
              state_q <= ST_RESP;
            end else begin
              wr_q    <= up_req_write;
              addr_q  <= up_req_addr;
              size_q  <= up_req_size;
              wdata_q <= up_req_wdata & lane_mask(up_req_size);
              sec_q   <= (action == ACT_ALLOW_S);
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: if (dn_req_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            rdata_q <= dn_rsp_rdata;
            err_q   <= dn_rsp_err;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: if (up_rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dn_req_valid  = (state_q == ST_ISSUE);
  assign dn_req_write  = wr_q;
  assign dn_req_addr   = addr_q;
  assign dn_req_size   = size_q;
  assign dn_req_wdata  = wdata_q;
  assign dn_req_secure = sec_q;
  assign dn_rsp_ready  = (state_q == ST_WAIT);
  assign up_rsp_valid  = (state_q == ST_RESP);
  assign up_rsp_rdata  = rdata_q;
  assign up_rsp_err    = err_q;

  assert_block_no_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && blocked |=> up_rsp_valid && !dn_req_valid);

  assert_razwi_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (action == ACT_RAZWI) |=> (up_rsp_rdata == '0) && !up_rsp_err);

  assert_abort_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (action == ACT_ABORT) |=> up_rsp_err);

  assert_dn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_secure));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid && !up_rsp_ready |=> up_rsp_valid && $stable(up_rsp_rdata) && $stable(up_rsp_err));

  assert_lanes_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> (dn_req_wdata & ~lane_mask(dn_req_size)) == '0);

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid || dn_req_valid || dn_rsp_ready) |-> !up_req_ready);

endmodule

// File: rtl/bus_sec_filter.sv
module bus_sec_filter
  import bsf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_nonsec,
  input  logic              cfg_sec_resp,
  input  logic              irq_clear,
  output logic              irq,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_write,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic [1:0]        up_req_size,
  input  logic [DATA_W-1:0] up_req_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_exempt,
  input  logic              lk_nonsec,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [1:0]        dn_req_size,
  output logic [DATA_W-1:0] dn_req_wdata,
  output logic              dn_req_secure,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err
);

  bsf_action_e action;
  logic        accept;
  logic        abort_evt;

  assign lk_addr = up_req_addr;

  bsf_decide decide_i (
    .lk_exempt    (lk_exempt),
    .lk_nonsec    (lk_nonsec),
    .cfg_nonsec   (cfg_nonsec),
    .cfg_sec_resp (cfg_sec_resp),
    .action       (action)
  );

  bsf_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) xfer_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .action        (action),
    .accept        (accept),
    .up_req_valid  (up_req_valid),
    .up_req_ready  (up_req_ready),
    .up_req_write  (up_req_write),
    .up_req_addr   (up_req_addr),
    .up_req_size   (up_req_size),
    .up_req_wdata  (up_req_wdata),
    .up_rsp_valid  (up_rsp_valid),
    .up_rsp_ready  (up_rsp_ready),
    .up_rsp_rdata  (up_rsp_rdata),
    .up_rsp_err    (up_rsp_err),
    .dn_req_valid  (dn_req_valid),
    .dn_req_ready  (dn_req_ready),
    .dn_req_write  (dn_req_write),
    .dn_req_addr   (dn_req_addr),
    .dn_req_size   (dn_req_size),
    .dn_req_wdata  (dn_req_wdata),
    .dn_req_secure (dn_req_secure),
    .dn_rsp_valid  (dn_rsp_valid),
    .dn_rsp_ready  (dn_rsp_ready),
    .dn_rsp_rdata  (dn_rsp_rdata),
    .dn_rsp_err    (dn_rsp_err)
  );

  assign abort_evt = accept && (action == ACT_ABORT);

  bsf_irq irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_evt  (abort_evt),
    .irq_clear  (irq_clear),
    .irq_status (irq)
  );

  assert_exempt_attr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && lk_exempt |=> dn_req_valid && (dn_req_secure == !$past(cfg_nonsec)));

  assert_nsregion_attr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lk_exempt && lk_nonsec |=> dn_req_valid && !dn_req_secure);

  assert_secure_attr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lk_exempt && !lk_nonsec && !cfg_nonsec |=> dn_req_valid && dn_req_secure);

  assert_block_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lk_exempt && !lk_nonsec && cfg_nonsec |=> !dn_req_valid && up_rsp_valid);

endmodule

// File: tb/bus_sec_filter_tb_top.sv
`timescale 1ns/1ps
module bus_sec_filter_tb_top;

  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_nonsec = 0, cfg_sec_resp = 0, irq_clear = 0;
  logic          irq;
  logic          up_req_valid = 0, up_req_write = 0;
  logic          up_req_ready;
  logic [AW-1:0] up_req_addr = '0;
  logic [1:0]    up_req_size = '0;
  logic [DW-1:0] up_req_wdata = '0;
  logic          up_rsp_valid, up_rsp_err;
  logic          up_rsp_ready = 1'b1;
  logic [DW-1:0] up_rsp_rdata;
  logic [AW-1:0] lk_addr;
  logic          lk_exempt, lk_nonsec;
  logic          dn_req_valid, dn_req_write, dn_req_secure, dn_rsp_ready;
  logic          dn_req_ready = 0;
  logic [AW-1:0] dn_req_addr;
  logic [1:0]    dn_req_size;
  logic [DW-1:0] dn_req_wdata;
  logic          dn_rsp_valid = 0, dn_rsp_err = 0;
  logic [DW-1:0] dn_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  // Lookup model: address bit 13 = exempt, bit 12 = non-secure region.
  assign lk_exempt = lk_addr[13];
  assign lk_nonsec = lk_addr[12];

  bus_sec_filter #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_nonsec(cfg_nonsec), .cfg_sec_resp(cfg_sec_resp),
    .irq_clear(irq_clear), .irq(irq),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_write(up_req_write),
    .up_req_addr(up_req_addr), .up_req_size(up_req_size), .up_req_wdata(up_req_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready), .up_rsp_rdata(up_rsp_rdata),
    .up_rsp_err(up_rsp_err), .lk_addr(lk_addr), .lk_exempt(lk_exempt), .lk_nonsec(lk_nonsec),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_write(dn_req_write),
    .dn_req_addr(dn_req_addr), .dn_req_size(dn_req_size), .dn_req_wdata(dn_req_wdata),
    .dn_req_secure(dn_req_secure), .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready),
    .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        cfg_ns;
    logic        sec_resp;
    logic        wr;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [63:0] wdata;
    logic [63:0] dn_rdata;
    logic        dn_err;
    logic        exp_fwd;
    logic        exp_sec;
    logic        exp_err;
    logic [63:0] exp_rdata;
    logic [63:0] exp_wdata;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    // R3: secure region, secure master, 8-byte read
    '{1'b0,1'b0,1'b0,2'd3,32'h0000_0040,64'h0,64'h1122_3344_5566_7788,1'b0, 1'b1,1'b1,1'b0,64'h1122_3344_5566_7788,64'h0,1'b0},
    // R2/R9: non-secure region, NS master, downstream error passed up
    '{1'b1,1'b0,1'b0,2'd2,32'h0000_1000,64'h0,64'h0000_0000_AAAA_BBBB,1'b1, 1'b1,1'b0,1'b1,64'h0000_0000_AAAA_BBBB,64'h0,1'b0},
    // R2/R10: non-secure region, 1-byte write, upper lanes zeroed
    '{1'b0,1'b1,1'b1,2'd0,32'h0000_1004,64'hFFFF_FFFF_FFFF_FFA5,64'h0,1'b0, 1'b1,1'b0,1'b0,64'h0,64'h0000_0000_0000_00A5,1'b0},
    // R1/R10: exempt, secure master, 2-byte write
    '{1'b0,1'b0,1'b1,2'd1,32'h0000_2008,64'h1234_5678_9ABC_DEF0,64'h0,1'b0, 1'b1,1'b1,1'b0,64'h0,64'h0000_0000_0000_DEF0,1'b0},
    // R1: exempt, NS master, 4-byte read
    '{1'b1,1'b0,1'b0,2'd2,32'h0000_200C,64'h0,64'h0000_0000_0000_CAFE,1'b0, 1'b1,1'b0,1'b0,64'h0000_0000_0000_CAFE,64'h0,1'b0},
    // R1: exempt with NS flag, NS master, 8-byte write
    '{1'b1,1'b1,1'b1,2'd3,32'h0000_3010,64'h0102_0304_0506_0708,64'h0,1'b0, 1'b1,1'b0,1'b0,64'h0,64'h0102_0304_0506_0708,1'b0},
    // R4/R5: blocked read, read-as-zero
    '{1'b1,1'b0,1'b0,2'd3,32'h0000_0020,64'h0,64'hDEAD_BEEF_DEAD_BEEF,1'b0, 1'b0,1'b0,1'b0,64'h0,64'h0,1'b0},
    // R4/R5: blocked write, discarded with OK
    '{1'b1,1'b0,1'b1,2'd2,32'h0000_0024,64'h5555_5555_5555_5555,64'h0,1'b0, 1'b0,1'b0,1'b0,64'h0,64'h0,1'b0},
    // R3: secure master, sec_resp high has no effect
    '{1'b0,1'b1,1'b0,2'd2,32'h0000_0028,64'h0,64'h0000_0000_0BAD_F00D,1'b0, 1'b1,1'b1,1'b0,64'h0000_0000_0BAD_F00D,64'h0,1'b0},
    // R6: blocked with error response, interrupt set
    '{1'b1,1'b1,1'b0,2'd2,32'h0000_0030,64'h0,64'h0,1'b0, 1'b0,1'b0,1'b1,64'h0,64'h0,1'b1}
  };

  // Drive one request; returns at the falling edge after acceptance.
  task automatic send(input logic cn, input logic sr, input logic wr, input logic [1:0] sz,
                      input logic [31:0] a, input logic [63:0] wd);
    @(negedge clk);
    cfg_nonsec = cn; cfg_sec_resp = sr;
    up_req_valid = 1; up_req_write = wr; up_req_size = sz; up_req_addr = a; up_req_wdata = wd;
    chk("R11 ready while idle", up_req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    up_req_valid = 0;
  endtask

  task automatic run_vec(input int k, input vec_t v);
    string t;
    t = $sformatf("vec%0d", k);
    send(v.cfg_ns, v.sec_resp, v.wr, v.size, v.addr, v.wdata);
    chk({t, " R4 dn_req_valid"}, dn_req_valid, v.exp_fwd);
    chk({t, " R4 rsp next cycle"}, up_rsp_valid, !v.exp_fwd);
    if (v.exp_fwd) begin
      chk({t, " R1/R2/R3 secure attr"}, dn_req_secure, v.exp_sec);
      chk({t, " R9 addr"}, dn_req_addr, v.addr);
      chk({t, " R9 write flag"}, dn_req_write, v.wr);
      chk({t, " R9 size"}, dn_req_size, v.size);
      if (v.wr) chk({t, " R10 wdata lanes"}, dn_req_wdata, v.exp_wdata);
      dn_req_ready = 1;
      @(posedge clk);
      @(negedge clk);
      dn_req_ready = 0;
      dn_rsp_valid = 1; dn_rsp_rdata = v.dn_rdata; dn_rsp_err = v.dn_err;
      @(posedge clk);
      @(negedge clk);
      dn_rsp_valid = 0;
      chk({t, " R9 rsp valid"}, up_rsp_valid, 1);
    end
    chk({t, " R11 not ready during rsp"}, up_req_ready, 0);
    chk({t, " R5/R9 rdata"}, up_rsp_rdata, v.exp_rdata);
    chk({t, " R5/R6/R9 err"}, up_rsp_err, v.exp_err);
    @(posedge clk);
    @(negedge clk);
    chk({t, " R6 irq"}, irq, v.exp_irq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 irq after reset", irq, 0);
    chk("R8 ready after reset", up_req_ready, 1);
    chk("R8 no rsp after reset", up_rsp_valid, 0);
    chk("R8 no dn req after reset", dn_req_valid, 0);

    for (int k = 0; k < NV; k++) run_vec(k, VECS[k]);

    // R6 sticky status, then R7 clear
    repeat (3) @(negedge clk);
    chk("R6 irq sticky", irq, 1);
    irq_clear = 1;
    @(negedge clk);
    chk("R7 irq cleared", irq, 0);
    // R7: abort accepted while clear held high
    send(1, 1, 0, 2'd2, 32'h0000_0034, 64'h0);
    chk("R6 abort err with clear held", up_rsp_err, 1);
    @(negedge clk);
    chk("R7 clear wins over abort", irq, 0);
    irq_clear = 0;
    @(negedge clk);
    chk("R7 irq stays low after release", irq, 0);

    // R11/R9: upstream response backpressure on a blocked read
    up_rsp_ready = 0;
    send(1, 0, 0, 2'd3, 32'h0000_0038, 64'h0);
    for (int i = 0; i < 3; i++) begin
      chk("R9 rsp held under backpressure", up_rsp_valid, 1);
      chk("R11 ready low under backpressure", up_req_ready, 0);
      @(negedge clk);
    end
    up_rsp_ready = 1;
    @(negedge clk);
    chk("R11 rsp done", up_rsp_valid, 0);
    chk("R11 ready again", up_req_ready, 1);

    // R9: downstream request stall
    send(0, 0, 0, 2'd2, 32'h0000_1040, 64'h0);
    for (int i = 0; i < 3; i++) begin
      chk("R9 dn req held", dn_req_valid, 1);
      chk("R9 dn addr stable", dn_req_addr, 32'h0000_1040);
      @(negedge clk);
    end
    dn_req_ready = 1;
    @(negedge clk);
    dn_req_ready = 0;
    chk("R9 dn req released", dn_req_valid, 0);
    dn_rsp_valid = 1; dn_rsp_rdata = 64'h7766_5544_3322_1100; dn_rsp_err = 0;
    @(negedge clk);
    dn_rsp_valid = 0;
    chk("R9 rdata after stall", up_rsp_rdata, 64'h7766_5544_3322_1100);
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule